// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual byte address into a 16-bit physical byte address. It reads two translation entries from a small word-addressed physical memory. A request is split into three fields. The top 12 bits select an entry in a directory page. The next 9 bits select an entry in a second-level page table. The low 11 bits are the byte offset within a 2 KiB page. The walker reads the directory entry, then the page-table entry it points to, and returns the physical page number joined to the offset.

Each 4-byte entry uses bit 0 as its valid flag and bits [15:11] as a 5-bit physical page number. All other entry bits are ignored. The directory entry names the page that holds the second-level table, and the page-table entry names the target page. If either entry is invalid, the walk ends with a fault response that reports which level failed. The caller supplies the directory's physical base address and holds it steady while a walk runs. The memory port keeps its request and address raised until the memory signals ready, so any read latency is accepted.

Top module: `pt_walker`

## Requirements
- R1: During and directly after reset, req_ready_o is 1, mem_req_o is 0 and resp_valid_o is 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. From the next cycle until the walk completes, req_ready_o is 0 and the first memory read is issued.
- R3: The first read address is dir_base_i + 4 × vaddr[31:20], computed modulo 2^16.
- R4: mem_req_o stays 1 with an unchanged mem_addr_o until a cycle in which mem_ready_i is 1. Read data is taken in that cycle, whatever the number of wait cycles.
- R5: If the directory entry is valid, the second read address is {entry[15:11], vaddr[19:11], 2'b00}.
- R6: If both entries are valid, the response carries resp_fault_o = 0 and resp_paddr_o = {pte[15:11], vaddr[10:0]}.
- R7: If bit 0 of the directory entry is 0, no second read is made. The response carries resp_fault_o = 1, resp_fault_lvl_o = 0 and resp_paddr_o = 0.
- R8: If bit 0 of the page-table entry is 0, the response carries resp_fault_o = 1, resp_fault_lvl_o = 1 and resp_paddr_o = 0.
- R9: resp_valid_o is high for exactly one cycle, and req_ready_o is 1 in the following cycle.
- R10: Entry bits other than bit 0 and bits [15:11] have no effect on read addresses or on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_base_i | input | 16 | Physical byte address of the directory page |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual byte address to translate |
| resp_valid_o | output | 1 | Response valid, one-cycle pulse |
| resp_fault_o | output | 1 | Walk hit an invalid entry |
| resp_fault_lvl_o | output | 1 | Level of the invalid entry: 0 directory, 1 page table |
| resp_paddr_o | output | 16 | Translated physical byte address, 0 on fault |
| mem_req_o | output | 1 | Memory read request, held until ready |
| mem_addr_o | output | 16 | Byte address of the entry being read |
| mem_ready_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench builds the walker with its default split: 32-bit virtual addresses, 9 table-index bits, 11 offset bits and a 16-bit physical address. With a 12-bit directory index, this makes it practical to walk every one of the 4096 directory entries. The memory model is a hash of the read address, so valid and invalid entries at both levels appear across the sweep, and the unused entry bits carry arbitrary values. A second pass with a directory base near the top of memory makes the directory address wrap. Read latency cycles through zero to three wait cycles.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_PT   = 2'd2,
    ST_RESP = 2'd3
  } walk_state_e;

  localparam int unsigned ENT_BYTES_LG2 = 2;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PTI_W  = 9,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned PA_W   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic [VA_W-1:0]            vaddr_i,
  input  logic [PA_W-1:0]            dir_base_i,
  input  logic [PA_W-OFF_W-1:0]      pt_ppn_i,
  input  logic [DATA_W-1:0]          entry_i,
  output logic [PA_W-1:0]            dir_addr_o,
  output logic [PA_W-1:0]            pte_addr_o,
  output logic [PA_W-OFF_W-1:0]      ent_ppn_o,
  output logic                       ent_valid_o,
  output logic [PA_W-1:0]            paddr_o
);
  localparam int unsigned DIRI_W = VA_W - PTI_W - OFF_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;

  logic [DIRI_W-1:0]               dir_idx;
  logic [PTI_W-1:0]                pt_idx;
  logic [DIRI_W+ENT_BYTES_LG2-1:0] dir_off;
  logic [PTI_W+ENT_BYTES_LG2-1:0]  pt_off;

  assign dir_idx = vaddr_i[VA_W-1 -: DIRI_W];
  assign pt_idx  = vaddr_i[OFF_W +: PTI_W];
  assign dir_off = {dir_idx, {ENT_BYTES_LG2{1'b0}}};
  assign pt_off  = {pt_idx, {ENT_BYTES_LG2{1'b0}}};

  // directory may sit anywhere; sum wraps modulo physical space
  assign dir_addr_o = dir_base_i + PA_W'(dir_off);
  // table is page aligned
  assign pte_addr_o = {pt_ppn_i, {OFF_W{1'b0}}} + PA_W'(pt_off);

  assign ent_valid_o = entry_i[0];
  assign ent_ppn_o   = entry_i[OFF_W +: PPN_W];
  assign paddr_o     = {entry_i[OFF_W +: PPN_W], vaddr_i[OFF_W-1:0]};
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned PA_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [VA_W-1:0]       req_vaddr_i,
  output logic [VA_W-1:0]       vaddr_o,
  input  logic [PA_W-1:0]       dir_addr_i,
  input  logic [PA_W-1:0]       pte_addr_i,
  input  logic                  ent_valid_i,
  input  logic [PA_W-OFF_W-1:0] ent_ppn_i,
  input  logic [PA_W-1:0]       paddr_i,
  output logic [PA_W-OFF_W-1:0] pt_ppn_o,
  output logic                  mem_req_o,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic                  mem_ready_i,
  output logic                  resp_valid_o,
  output logic                  resp_fault_o,
  output logic                  resp_fault_lvl_o,
  output logic [PA_W-1:0]       resp_paddr_o
);
  localparam int unsigned PPN_W = PA_W - OFF_W;

  walk_state_e      state_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [PPN_W-1:0] pt_ppn_q;
  logic             fault_q;
  logic             lvl_q;
  logic [PA_W-1:0]  paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      vaddr_q  <= '0;
      pt_ppn_q <= '0;
      fault_q  <= 1'b0;
      lvl_q    <= 1'b0;
      paddr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            vaddr_q <= req_vaddr_i;
            state_q <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ready_i) begin
            if (!ent_valid_i) begin
              fault_q <= 1'b1;
              lvl_q   <= 1'b0;
              paddr_q <= '0;
              state_q <= ST_RESP;
            end else begin
              pt_ppn_q <= ent_ppn_i;
              state_q  <= ST_PT;
            end
          end
        end
        ST_PT: begin
          if (mem_ready_i) begin
            fault_q <= !ent_valid_i;
            lvl_q   <= !ent_valid_i;
            paddr_q <= ent_valid_i ? paddr_i : '0;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign mem_req_o        = (state_q == ST_DIR) || (state_q == ST_PT);
  assign mem_addr_o       = (state_q == ST_PT) ? pte_addr_i : dir_addr_i;
  assign vaddr_o          = vaddr_q;
  assign pt_ppn_o         = pt_ppn_q;
  assign resp_valid_o     = (state_q == ST_RESP);
  assign resp_fault_o     = fault_q;
  assign resp_fault_lvl_o = lvl_q;
  assign resp_paddr_o     = paddr_q;

  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o && mem_req_o); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R4

  AST_DIR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIR) && mem_ready_i && !ent_valid_i
      |=> resp_valid_o && resp_fault_o && !resp_fault_lvl_o); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_fault_o |-> resp_paddr_o == '0); // R8

  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_fault_o
      |-> resp_paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]); // R6

  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o && req_ready_o); // R9
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PTI_W  = 9,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned PA_W   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PA_W-1:0]   dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic              resp_fault_lvl_o,
  output logic [PA_W-1:0]   resp_paddr_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned PPN_W = PA_W - OFF_W;

  logic [VA_W-1:0]  vaddr;
  logic [PA_W-1:0]  dir_addr;
  logic [PA_W-1:0]  pte_addr;
  logic [PPN_W-1:0] pt_ppn;
  logic [PPN_W-1:0] ent_ppn;
  logic             ent_valid;
  logic [PA_W-1:0]  paddr;

  pt_addr_gen #(
    .VA_W(VA_W), .PTI_W(PTI_W), .OFF_W(OFF_W), .PA_W(PA_W), .DATA_W(DATA_W)
  ) u_addr_gen (
    .vaddr_i     (vaddr),
    .dir_base_i  (dir_base_i),
    .pt_ppn_i    (pt_ppn),
    .entry_i     (mem_rdata_i),
    .dir_addr_o  (dir_addr),
    .pte_addr_o  (pte_addr),
    .ent_ppn_o   (ent_ppn),
    .ent_valid_o (ent_valid),
    .paddr_o     (paddr)
  );

  pt_walk_fsm #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_vaddr_i      (req_vaddr_i),
    .vaddr_o          (vaddr),
    .dir_addr_i       (dir_addr),
    .pte_addr_i       (pte_addr),
    .ent_valid_i      (ent_valid),
    .ent_ppn_i        (ent_ppn),
    .paddr_i          (paddr),
    .pt_ppn_o         (pt_ppn),
    .mem_req_o        (mem_req_o),
    .mem_addr_o       (mem_addr_o),
    .mem_ready_i      (mem_ready_i),
    .resp_valid_o     (resp_valid_o),
    .resp_fault_o     (resp_fault_o),
    .resp_fault_lvl_o (resp_fault_lvl_o),
    .resp_paddr_o     (resp_paddr_o)
  );
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dir_base = 16'h0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, resp_valid, resp_fault, resp_lvl, mem_req;
  logic [15:0] resp_paddr, mem_addr;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  int hold_err = 0;
  int lat_cnt = 0;
  int cyc = 0;
  int n_ok = 0, n_f0 = 0, n_f1 = 0;
  logic [15:0] rd_log [0:3];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .dir_base_i(dir_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
    .resp_fault_lvl_o(resp_lvl), .resp_paddr_o(resp_paddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] memf(input logic [15:0] a);
    logic [31:0] x;
    x = {a, a} * 32'h9E3779B1;
    x = x ^ (x >> 15);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // memory responder, 0..3 wait cycles
  initial begin
    logic [15:0] cur;
    int wait_left;
    bit busy;
    busy = 0;
    cur = '0;
    wait_left = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        busy = 0;
      end
      if (rst_n && mem_req) begin
        if (!busy) begin
          busy = 1;
          cur = mem_addr;
          wait_left = lat_cnt % 4;
          lat_cnt++;
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
        end else if (mem_addr !== cur) begin
          hold_err++;
        end
        if (wait_left == 0) begin
          mem_ready = 1'b1;
          mem_rdata = memf(cur);
        end else begin
          wait_left--;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        summary();
      end
    end
  end

  task automatic walk(input logic [31:0] va);
    logic [15:0] d_addr, p_addr, exp_pa;
    logic [31:0] de, pe;
    int t;
    bit got;
    rd_cnt = 0;
    hold_err = 0;
    @(negedge clk);
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 busy after accept", 32'(req_ready), 0);
    got = 0;
    for (t = 0; t < 100; t++) begin
      if (resp_valid) begin got = 1; break; end
      @(negedge clk);
    end
    check(got, "R4 response arrives", 32'(got), 1);
    if (!got) return;
    d_addr = dir_base + {2'b00, va[31:20], 2'b00};
    de = memf(d_addr);
    check(rd_log[0] == d_addr, "R3 directory read address", 32'(rd_log[0]), 32'(d_addr));
    check(hold_err == 0, "R4 address held", hold_err, 0);
    if (!de[0]) begin
      n_f0++;
      check(rd_cnt == 1 && resp_fault && !resp_lvl && resp_paddr == 0,
            "R7 directory fault", {rd_cnt[13:0], resp_fault, resp_lvl, resp_paddr},
            {14'd1, 1'b1, 1'b0, 16'h0});
    end else begin
      p_addr = {de[15:11], va[19:11], 2'b00};
      pe = memf(p_addr);
      // R10: hash leaves arbitrary values in unused entry bits
      check(rd_cnt == 2 && rd_log[1] == p_addr, "R5 R10 table read address",
            {rd_cnt[15:0], rd_log[1]}, {16'd2, p_addr});
      if (!pe[0]) begin
        n_f1++;
        check(resp_fault && resp_lvl && resp_paddr == 0, "R8 table fault",
              {resp_fault, resp_lvl, resp_paddr}, {1'b1, 1'b1, 16'h0});
      end else begin
        n_ok++;
        exp_pa = {pe[15:11], va[10:0]};
        check(!resp_fault && resp_paddr == exp_pa, "R6 R10 translated address",
              {resp_fault, resp_paddr}, {1'b0, exp_pa});
      end
    end
    @(negedge clk);
    check(!resp_valid && req_ready, "R9 pulse then ready",
          {resp_valid, req_ready}, 32'b01);
  endtask

  initial begin
    #1;
    check(req_ready && !mem_req && !resp_valid, "R1 in reset",
          {req_ready, mem_req, resp_valid}, 32'b100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req && !resp_valid, "R1 after reset",
          {req_ready, mem_req, resp_valid}, 32'b100);
    dir_base = 16'h0000;
    for (int i = 0; i < 4096; i++)
      walk({i[11:0], 9'((i * 37) % 512), 11'((i * 131) % 2048)});
    dir_base = 16'hF000;
    for (int i = 0; i < 512; i++)
      walk({12'(i * 8 + 7), 9'((i * 53) % 512), 11'((i * 977) % 2048)});
    check(n_ok > 0, "R6 success seen", n_ok, 1);
    check(n_f0 > 0, "R7 directory fault seen", n_f0, 1);
    check(n_f1 > 0, "R8 table fault seen", n_f1, 1);
    summary();
  end
endmodule